// File: doc/BRIEF.md
# Buck Gate-Drive Sequencer with Duty Cap and Dead Time

This block sits between the analog PWM comparator of a voltage-mode synchronous buck regulator and the two power-switch drivers. Each cycle it takes the raw comparator bit and turns it into two on commands, one for the high-side switch and one for the low-side switch. It applies three rules that the analog loop cannot be trusted to apply for itself.

The first rule is a duty-cycle cap. A period counter restarts on every oscillator strobe, and it forces the high side off at nine tenths of the period. The second rule is an over-current blank: once the over-current flag has been seen, the high side stays off until the next period begins. The third rule is break-before-make sequencing. Neither command may rise until the registered value of the opposite command has been seen low, followed by a programmable number of dead cycles.

The switching period is set by the oscillator strobe. The typical operating rate is a little under 1 MHz, which is several tens of fast clock cycles per period. An enable input shuts the stage down. After enable rises, high-side switching begins only at the next strobe, so the first pulse is never a truncated one.

Top module: `buck_gate_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, both `hs_on` and `ls_on` are 0.
- R2: With no over-current event, the high-side command follows the synchronized PWM bit within the open part of the period. In a period whose raw PWM is high for the first `d` cycles after the strobe, `hs_on` is high for max(0, min(d+1, LIMIT) + 1 − (s + DEAD_CYC)) cycles, where s is 1 if PWM was high at the end of the previous period and 2 otherwise.
- R3: LIMIT = floor(9·PERIOD_CYC/10). From the point where the period counter reaches LIMIT, the high side is forced off until the next strobe. When PWM is held high, `hs_on` is high for at most LIMIT cycles of a period.
- R4: No period is ever spent entirely with `hs_on` high; every period contains cycles with the high side off.
- R5: A high level on the synchronized over-current flag turns `hs_on` off on the next edge. The high side then stays off for the rest of that period, whatever PWM does, and the block is released only by the next strobe.
- R6: `hs_on` and `ls_on` are never both 1. When one command falls and the other then rises, both are 0 for at least DEAD_CYC cycles in between. These gaps last exactly DEAD_CYC cycles when the new request is already waiting.
- R7: `pwm_raw` and `ocp_raw` each pass through a SYNC_STAGES-flop synchronizer (default 2). A level sampled at edge k is acted on by the request logic at edge k+2.
- R8: When `en` is 0, both commands are 0 from the next edge on, and the period arming is cleared. After `en` returns to 1, neither command turns on until a strobe has been sampled.
- R9: While enabled and armed, the low side is requested whenever the high side is not requested. This includes after a duty cap and after an over-current blank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Stage enable; 0 forces both switches off |
| period_strobe | input | 1 | One-cycle pulse from the oscillator marking the start of a period |
| pwm_raw | input | 1 | Raw PWM comparator output (asynchronous) |
| ocp_raw | input | 1 | Raw over-current flag (asynchronous) |
| hs_on | output | 1 | High-side switch on command |
| ls_on | output | 1 | Low-side switch on command |

## Verification
The stimulus drives PWM pulse widths that separate the possible outcomes:
- A zero width checks that the low side stays on for the whole period.
- Short and medium widths check that the high-side on-time tracks PWM, less the dead time and the synchronizer latency.
- Full widths applied twice in a row check that the duty cap, and not PWM, ends the pulse. They also show the one-cycle difference when PWM was already high at the period boundary.

Over-current pulses are placed both inside and after the PWM pulse. This separates a blanked period from one the flag does not affect, and the period that follows checks that the latch has been released. An enable drop mid-run, and a re-enable mid-period, show that switching restarts only on a strobe.

// File: rtl/buck_gate_pkg.sv
`timescale 1ns/1ps
package buck_gate_pkg;

  // High-side cutoff point inside a period: nine tenths, rounded down.
  function automatic int unsigned duty_cutoff(input int unsigned period_cyc);
    return (period_cyc * 9) / 10;
  endfunction

  // Width needed to hold values 0..max_val.
  function automatic int unsigned hold_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/bgd_sync.sv
`timescale 1ns/1ps
module bgd_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= '0;
        else        stage_q[i] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= '0;
        else        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/bgd_period_guard.sv
`timescale 1ns/1ps
module bgd_period_guard
  import buck_gate_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic strobe,
  input  logic pwm_s,
  input  logic ocp_s,
  output logic hs_req,
  output logic ls_req,
  output logic clamp_hit,
  output logic ocp_hold,
  output logic armed
);

  localparam int unsigned CUTOFF = duty_cutoff(PERIOD_CYC);
  localparam int unsigned CW     = hold_width(CUTOFF);

  logic [CW-1:0] pos_q;
  logic          ocp_lat_q;
  logic          window;

  // Position in the period, saturating at the cutoff (window closed).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pos_q <= CW'(CUTOFF);
    else if (strobe)             pos_q <= '0;
    else if (pos_q < CW'(CUTOFF)) pos_q <= pos_q + CW'(1);
  end

  // Arming: switching may begin only after a strobe seen while enabled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed <= 1'b0;
    else if (!en)    armed <= 1'b0;
    else if (strobe) armed <= 1'b1;
  end

  // Over-current latch: a set beats the strobe clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ocp_lat_q <= 1'b0;
    else if (ocp_s)  ocp_lat_q <= 1'b1;
    else if (strobe) ocp_lat_q <= 1'b0;
  end

  assign clamp_hit = (pos_q == CW'(CUTOFF));
  assign window    = armed && !clamp_hit;
  assign ocp_hold  = ocp_s || ocp_lat_q;
  assign hs_req    = en && window && pwm_s && !ocp_hold;
  assign ls_req    = en && armed && !hs_req;

  AST_ARM_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(strobe)); // R8

  AST_OCP_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ocp_hold && !strobe) |=> ocp_hold); // R5

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_req && ls_req)); // R9

endmodule

// File: rtl/bgd_deadtime.sv
`timescale 1ns/1ps
module bgd_deadtime
  import buck_gate_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic hs_req,
  input  logic ls_req,
  output logic hs_on,
  output logic ls_on
);

  localparam int unsigned DW = hold_width(DEAD_CYC);

  logic [DW-1:0] idle_q;
  logic          both_off;
  logic          gap_done;
  logic          hs_nx;
  logic          ls_nx;

  assign both_off = !hs_on && !ls_on;
  assign gap_done = (32'(idle_q) + 32'd1) >= 32'(DEAD_CYC);

  // Count cycles in which both registered commands have been seen off.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       idle_q <= '0;
    else if (!both_off)               idle_q <= '0;
    else if (idle_q < DW'(DEAD_CYC))  idle_q <= idle_q + DW'(1);
  end

  // A command holds while requested; it may only start once both sides are off and the gap has run.
  assign hs_nx = en && hs_req && (hs_on || (both_off && gap_done));
  assign ls_nx = en && ls_req && (ls_on || (both_off && gap_done));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_on <= 1'b0;
      ls_on <= 1'b0;
    end else begin
      hs_on <= hs_nx;
      ls_on <= ls_nx;
    end
  end

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on && ls_on)); // R6

  AST_HS_AFTER_LS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on) |-> !$past(ls_on)); // R6

  AST_LS_AFTER_HS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_on) |-> !$past(hs_on)); // R6

endmodule

// File: rtl/buck_gate_ctrl.sv
`timescale 1ns/1ps
module buck_gate_ctrl #(
  parameter int unsigned PERIOD_CYC  = 40,
  parameter int unsigned DEAD_CYC    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic period_strobe,
  input  logic pwm_raw,
  input  logic ocp_raw,
  output logic hs_on,
  output logic ls_on
);

  logic [1:0] raw_bus;
  logic [1:0] sync_bus;
  logic       pwm_s;
  logic       ocp_s;
  logic       hs_req;
  logic       ls_req;
  logic       clamp_hit;
  logic       ocp_hold;
  logic       armed;

  assign raw_bus = {ocp_raw, pwm_raw};

  bgd_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (raw_bus),
    .q_sync  (sync_bus)
  );

  assign pwm_s = sync_bus[0];
  assign ocp_s = sync_bus[1];

  bgd_period_guard #(
    .PERIOD_CYC (PERIOD_CYC)
  ) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .strobe    (period_strobe),
    .pwm_s     (pwm_s),
    .ocp_s     (ocp_s),
    .hs_req    (hs_req),
    .ls_req    (ls_req),
    .clamp_hit (clamp_hit),
    .ocp_hold  (ocp_hold),
    .armed     (armed)
  );

  bgd_deadtime #(
    .DEAD_CYC (DEAD_CYC)
  ) u_dead (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .hs_req (hs_req),
    .ls_req (ls_req),
    .hs_on  (hs_on),
    .ls_on  (ls_on)
  );

  AST_CAP_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_hit |=> !hs_on); // R3

  AST_OCP_BLANKS_HS: assert property (@(posedge clk) disable iff (!rst_n)
    ocp_hold |=> !hs_on); // R5

  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!hs_on && !ls_on)); // R8

  AST_UNARMED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (!hs_on && !ls_on)); // R8

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (!hs_on && !ls_on)); // R1

endmodule

// File: tb/buck_gate_ctrl_bench.sv
`timescale 1ns/1ps
module buck_gate_ctrl_bench;

  localparam int PERIOD = 40;
  localparam int DEAD   = 2;
  localparam int NROWS  = 9;
  // Cutoff restated: the period minus a tenth rounded up.
  localparam int CAP    = PERIOD - (PERIOD + 9) / 10;

  // Vector table: PWM-high width after the strobe, and the over-current pulse position (-1 = none).
  localparam int ROW_DUTY [NROWS] = '{0, 20, 40, 40, 30, 3, 40, 40, 25};
  localparam int ROW_OCP  [NROWS] = '{-1, -1, -1, -1, -1, -1, 10, -1, 30};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic period_strobe = 1'b0;
  logic pwm_raw = 1'b0;
  logic ocp_raw = 1'b0;
  logic hs_on;
  logic ls_on;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  buck_gate_ctrl #(
    .PERIOD_CYC  (PERIOD),
    .DEAD_CYC    (DEAD),
    .SYNC_STAGES (2)
  ) u_buck_gate_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .period_strobe (period_strobe),
    .pwm_raw       (pwm_raw),
    .ocp_raw       (ocp_raw),
    .hs_on         (hs_on),
    .ls_on         (ls_on)
  );

  // Gap monitor for side-to-side hand-overs (R6).
  int  off_run = 0;
  int  last_side = 0;
  int  min_gap = 1000;
  int  overlap = 0;
  bit  p_hs = 1'b0;
  bit  p_ls = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (hs_on && ls_on) overlap++;
      if (hs_on && !p_hs) begin
        if (last_side == 2 && off_run < min_gap) min_gap = off_run;
        last_side = 1;
      end
      if (ls_on && !p_ls) begin
        if (last_side == 1 && off_run < min_gap) min_gap = off_run;
        last_side = 2;
      end
      if (!hs_on && !ls_on) off_run++;
      else off_run = 0;
      p_hs = hs_on;
      p_ls = ls_on;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_hs(input int duty, input int ocp, input bit prev_full);
    int s;
    int e;
    s = (prev_full ? 1 : 2) + DEAD;
    e = ((duty + 1 < CAP) ? duty + 1 : CAP) + 1;
    if (ocp >= 0 && ocp + 2 < e) e = ocp + 2;
    return (e > s) ? e - s : 0;
  endfunction

  // One switching period; en_from >= 0 raises en at that cycle, en_low holds en at 0.
  task automatic run_period(input int duty, input int ocp, input int en_from, input bit en_low,
                            output int hs_cnt, output int ls_cnt, output int hs_off);
    hs_cnt = 0;
    ls_cnt = 0;
    hs_off = 0;
    for (int k = 0; k < PERIOD; k++) begin
      @(negedge clk);
      if (k >= 1) begin
        if (hs_on) hs_cnt++; else hs_off++;
        if (ls_on) ls_cnt++;
      end
      period_strobe = (k == 0);
      pwm_raw = (k < duty);
      ocp_raw = (k == ocp);
      if (en_low) en = 1'b0;
      else if (en_from >= 0) en = (k >= en_from);
    end
    @(negedge clk);
    if (hs_on) hs_cnt++; else hs_off++;
    if (ls_on) ls_cnt++;
  endtask

  initial begin
    int hs_c;
    int ls_c;
    int hs_o;
    int prev_duty;
    int exp;

    repeat (3) @(negedge clk);
    check(!hs_on && !ls_on, "R1 reset hs/ls", {hs_on, ls_on}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!hs_on && !ls_on, "R1 after release", {hs_on, ls_on}, 0);

    en = 1'b1;
    // Each run_period call after the first consumes the trailing sample edge; keep it aligned.
    run_period(0, -1, -1, 1'b0, hs_c, ls_c, hs_o);
    prev_duty = 0;

    for (int r = 0; r < NROWS; r++) begin
      run_period(ROW_DUTY[r], ROW_OCP[r], -1, 1'b0, hs_c, ls_c, hs_o);
      exp = expect_hs(ROW_DUTY[r], ROW_OCP[r], prev_duty >= PERIOD);
      if (ROW_OCP[r] >= 0)
        check(hs_c == exp, "R5 R7 hs on-time with over-current", hs_c, exp);
      else
        check(hs_c == exp, "R2 R7 hs on-time", hs_c, exp);
      check(hs_c <= CAP, "R3 on-time within cap", hs_c, CAP);
      check(hs_o > 0, "R4 hs off somewhere in period", hs_o, 1);
      if (ROW_DUTY[r] == 0)
        check(ls_c == PERIOD, "R9 low side holds through idle period", ls_c, PERIOD);
      prev_duty = ROW_DUTY[r];
    end
    check(overlap == 0, "R6 no overlap over table", overlap, 0);
    check(min_gap == DEAD, "R6 hand-over dead gap", min_gap, DEAD);

    // Enable dropped for a whole period: both sides off.
    run_period(40, -1, -1, 1'b1, hs_c, ls_c, hs_o);
    check(hs_c == 0, "R8 hs off while disabled", hs_c, 0);
    check(ls_c == 0, "R8 ls off while disabled", ls_c, 0);
    // Re-enabled mid-period: nothing until the next strobe.
    run_period(40, -1, 5, 1'b0, hs_c, ls_c, hs_o);
    check(hs_c == 0 && ls_c == 0, "R8 idle until strobe after enable", hs_c + ls_c, 0);
    // First armed period: both sides start from idle, so the high side starts at once and the cap ends it.
    run_period(40, -1, -1, 1'b0, hs_c, ls_c, hs_o);
    check(hs_c == CAP, "R8 R3 first period after enable", hs_c, CAP);
    check(overlap == 0, "R6 no overlap overall", overlap, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule